// File: doc/BRIEF.md
# Per-Area Read Wait-State Controller

This block sets the length of every read bus cycle in an address map that is split into eight areas. For each area a programmable control bit, combined with the kind of memory mapped behind that area, decides how many clocks a read takes and whether an external wait input may stretch it. Normal external areas either finish in one clock or insert a two-clock wait. Three of the areas instead insert a long wait whose length is chosen on an input. DRAM switches between a short and a long column-address pitch. Multiplexed I/O always inserts four wait clocks. On-chip peripherals and on-chip memory have fixed lengths.

A bus master raises `rd_req` with the target's area number and space code. The block captures the timing for that read at the accepting edge, runs it to the end and strobes `rd_done` during the final clock. A small register holds the eight per-area bits and one write-wait bit. The write-wait bit can only be cleared when area 1 is mapped as DRAM.

Top module: `rws_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 16'hFFFF, and `rd_done` and `wait_active` are 0.
- R2: A register write stores `reg_wdata[15:8]` as the control bits, with area n at bit 8+n. Bits 7:2 and bit 0 always read 1, and writes to them are ignored.
- R3: Bit 1 is the write-wait bit. Writing 1 always sets it. Writing 0 clears it only while `area1_dram` is 1; otherwise it keeps its value.
- R4: Space code 0 (normal external) on area 1, 3, 4, 5 or 7 with its bit at 0 gives a 1-clock read, and `wait_in` has no effect.
- R5: Space code 0 on area 1, 3, 4, 5 or 7 with its bit at 1 gives a 3-clock read. The final clock repeats for as long as `wait_in` is 1 at its closing edge.
- R6: Space code 0 on area 0, 2 or 6 gives a read of 1 + (`long_sel`+1) clocks. `wait_in` is sampled at the last clock only when that area's bit is 1.
- R7: Space code 1 (DRAM) gives a 1-clock read that ignores `wait_in` when the area's bit is 0. When the bit is 1 it gives a 3-clock read stretched by `wait_in`.
- R8: Space code 2 (multiplexed I/O) gives a 5-clock read stretched by `wait_in`, whatever the bit value.
- R9: Space code 3 (on-chip peripheral) gives a fixed 3-clock read. Codes 4 to 7 (on-chip memory) give a fixed 1-clock read. `wait_in` and the bit have no effect on either.
- R10: `rd_done` is high for exactly one clock, the last clock of the read. A `rd_req` raised while a read is in progress is ignored.
- R11: `wait_active` is high in every clock of a read after its first clock, and low at all other times.
- R12: The timing of a read is fixed at the edge that accepts it. A register write during the read does not change that read's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request, accepted on a rising edge while idle |
| area | input | 3 | Target area number 0 to 7 |
| space | input | 3 | Memory type code of the target |
| long_sel | input | 2 | Long-wait length minus one for areas 0, 2 and 6 |
| wait_in | input | 1 | External wait request, active high |
| area1_dram | input | 1 | Area 1 is mapped as DRAM |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read value |
| rd_done | output | 1 | Final clock of the read |
| wait_active | output | 1 | Read is in a wait clock |

## Verification
A read accepted at a rising edge occupies the clocks that follow it. `rd_done` rises in clock N, where N is the programmed length, or W+1 when `wait_in` is sampled and held through W edges. `wait_active` rises in clock 2 of the read. The scoreboard starts counting at the accepting edge and samples on falling edges. It compares the count at the falling edge where `rd_done` is seen with the queued length, and it compares `wait_active` against the count in every clock. Register effects show on `reg_rdata` one edge after the write and are read at the following falling edge. `wait_in` is released one nanosecond after a rising edge, so it never changes at a sampling point.

// File: rtl/rws_pkg.sv
package rws_pkg;
   localparam int SPACE_W  = 3;
   localparam int REG_W    = 16;
   localparam int CTRL_LSB = 8;
   localparam int WW_BIT   = 1;

   localparam logic [SPACE_W-1:0] SP_EXT    = 3'd0;
   localparam logic [SPACE_W-1:0] SP_DRAM   = 3'd1;
   localparam logic [SPACE_W-1:0] SP_MUXIO  = 3'd2;
   localparam logic [SPACE_W-1:0] SP_PERIPH = 3'd3;
endpackage

// File: rtl/rws_cfg_reg.sv
module rws_cfg_reg
   import rws_pkg::*;
#(
   parameter int N_AREAS = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [REG_W-1:0]   wdata,
   input  logic               area1_dram,
   output logic [REG_W-1:0]   rdata,
   output logic [N_AREAS-1:0] rw_bits
);
   logic [N_AREAS-1:0] rw_q;
   logic               ww_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rw_q <= '1;
         ww_q <= 1'b1;
      end else if (we) begin
         rw_q <= wdata[CTRL_LSB +: N_AREAS];
         // clearing the write-wait bit is legal only with area 1 as DRAM
         if (wdata[WW_BIT] || area1_dram)
            ww_q <= wdata[WW_BIT];
      end
   end

   always_comb begin
      rdata                      = '1;
      rdata[CTRL_LSB +: N_AREAS] = rw_q;
      rdata[WW_BIT]              = ww_q;
   end

   assign rw_bits = rw_q;
endmodule

// File: rtl/rws_len_calc.sv
module rws_len_calc
   import rws_pkg::*;
#(
   parameter int                 N_AREAS        = 8,
   parameter int                 AREA_W         = 3,
   parameter logic [N_AREAS-1:0] LONG_AREA_MASK = 8'h45,
   parameter int                 LSEL_W         = 2,
   parameter int                 NORM_WAIT      = 2,
   parameter int                 MUX_WAIT       = 4,
   parameter int                 PERIPH_CYC     = 3,
   parameter int                 CYC_W          = 3
) (
   input  logic [AREA_W-1:0]  area,
   input  logic [SPACE_W-1:0] space,
   input  logic [LSEL_W-1:0]  long_sel,
   input  logic [N_AREAS-1:0] rw_bits,
   output logic [CYC_W-1:0]   cycles,
   output logic               wait_en
);
   logic [CYC_W-1:0] area_cyc [N_AREAS];
   logic             area_smp [N_AREAS];

   for (genvar i = 0; i < N_AREAS; i++) begin : g_area
      if (LONG_AREA_MASK[i]) begin : g_long
         // one base clock plus a long wait of long_sel+1 clocks
         assign area_cyc[i] = CYC_W'(2) + CYC_W'(long_sel);
         assign area_smp[i] = rw_bits[i];
      end else begin : g_norm
         assign area_cyc[i] = rw_bits[i] ? CYC_W'(1 + NORM_WAIT) : CYC_W'(1);
         assign area_smp[i] = rw_bits[i];
      end
   end

   logic sel_bit;
   assign sel_bit = rw_bits[area];

   always_comb begin
      case (space)
         SP_EXT: begin
            cycles  = area_cyc[area];
            wait_en = area_smp[area];
         end
         SP_DRAM: begin
            cycles  = sel_bit ? CYC_W'(1 + NORM_WAIT) : CYC_W'(1);
            wait_en = sel_bit;
         end
         SP_MUXIO: begin
            cycles  = CYC_W'(1 + MUX_WAIT);
            wait_en = 1'b1;
         end
         SP_PERIPH: begin
            cycles  = CYC_W'(PERIPH_CYC);
            wait_en = 1'b0;
         end
         default: begin
            cycles  = CYC_W'(1);
            wait_en = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/rws_seq.sv
module rws_seq #(
   parameter int CYC_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CYC_W-1:0] cycles,
   input  logic             wait_en,
   input  logic             wait_in,
   output logic             done,
   output logic             in_wait
);
   logic             busy_q;
   logic             first_q;
   logic             smp_q;
   logic [CYC_W-1:0] cnt_q;
   logic             last;
   logic             hold;

   assign last    = busy_q && (cnt_q == '0);
   assign hold    = smp_q && wait_in;
   assign done    = last && !hold;
   assign in_wait = busy_q && !first_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         first_q <= 1'b0;
         smp_q   <= 1'b0;
         cnt_q   <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q  <= 1'b1;
            first_q <= 1'b1;
            cnt_q   <= cycles - CYC_W'(1);
            // external wait is only looked at when wait clocks exist
            smp_q   <= wait_en && (cycles > CYC_W'(1));
         end
      end else begin
         first_q <= 1'b0;
         if (cnt_q != '0)
            cnt_q <= cnt_q - CYC_W'(1);
         else if (!hold)
            busy_q <= 1'b0;
      end
   end
endmodule

// File: rtl/rws_ctrl.sv
module rws_ctrl
   import rws_pkg::*;
#(
   parameter int   N_AREAS        = 8,
   parameter logic [7:0] LONG_AREA_MASK = 8'h45,
   parameter int   LSEL_W         = 2,
   parameter int   NORM_WAIT      = 2,
   parameter int   MUX_WAIT       = 4,
   parameter int   PERIPH_CYC     = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       rd_req,
   input  logic [$clog2(N_AREAS)-1:0] area,
   input  logic [2:0]                 space,
   input  logic [LSEL_W-1:0]          long_sel,
   input  logic                       wait_in,
   input  logic                       area1_dram,
   input  logic                       reg_we,
   input  logic [15:0]                reg_wdata,
   output logic [15:0]                reg_rdata,
   output logic                       rd_done,
   output logic                       wait_active
);
   localparam int AREA_W   = $clog2(N_AREAS);
   localparam int LONG_MAX = 1 << LSEL_W;
   localparam int M_A      = (1 + NORM_WAIT) > (1 + MUX_WAIT) ? (1 + NORM_WAIT) : (1 + MUX_WAIT);
   localparam int M_B      = PERIPH_CYC > (1 + LONG_MAX) ? PERIPH_CYC : (1 + LONG_MAX);
   localparam int MAX_CYC  = M_A > M_B ? M_A : M_B;
   localparam int CYC_W    = $clog2(MAX_CYC + 1);

   if (N_AREAS != REG_W - CTRL_LSB) begin : g_bad_areas
      $error("rws_ctrl: N_AREAS must fill the upper register byte");
   end
   if (NORM_WAIT < 1 || MUX_WAIT < 1 || PERIPH_CYC < 1) begin : g_bad_wait
      $error("rws_ctrl: wait and cycle counts must be at least 1");
   end
   if (LSEL_W < 1) begin : g_bad_lsel
      $error("rws_ctrl: LSEL_W must be at least 1");
   end

   logic [N_AREAS-1:0] rw_bits;
   logic [CYC_W-1:0]   cycles;
   logic               wait_en;

   rws_cfg_reg #(.N_AREAS(N_AREAS)) u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (reg_we),
      .wdata      (reg_wdata),
      .area1_dram (area1_dram),
      .rdata      (reg_rdata),
      .rw_bits    (rw_bits)
   );

   rws_len_calc #(
      .N_AREAS        (N_AREAS),
      .AREA_W         (AREA_W),
      .LONG_AREA_MASK (LONG_AREA_MASK[N_AREAS-1:0]),
      .LSEL_W         (LSEL_W),
      .NORM_WAIT      (NORM_WAIT),
      .MUX_WAIT       (MUX_WAIT),
      .PERIPH_CYC     (PERIPH_CYC),
      .CYC_W          (CYC_W)
   ) u_len (
      .area     (area),
      .space    (space),
      .long_sel (long_sel),
      .rw_bits  (rw_bits),
      .cycles   (cycles),
      .wait_en  (wait_en)
   );

   rws_seq #(.CYC_W(CYC_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (rd_req),
      .cycles  (cycles),
      .wait_en (wait_en),
      .wait_in (wait_in),
      .done    (rd_done),
      .in_wait (wait_active)
   );
endmodule

// File: rtl/rws_ctrl_chk.sv
module rws_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_we,
   input logic [15:0] reg_wdata,
   input logic        area1_dram,
   input logic [15:0] reg_rdata,
   input logic        rd_done,
   input logic        wait_active
);
   a_r2_low_ones : assert property (@(posedge clk) disable iff (!rst_n)
      rd_done || !rd_done |-> ((&reg_rdata[7:2]) && reg_rdata[0]));

   a_r3_ww_guard : assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && !reg_wdata[1] && !area1_dram) |=> (reg_rdata[1] == $past(reg_rdata[1])));

   a_r10_done_single : assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |=> !rd_done);

   a_r11_idle_after_done : assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |=> !wait_active);

   a_r11_wait_ends_on_done : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wait_active) |-> $past(rd_done));
endmodule

bind rws_ctrl rws_ctrl_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_we      (reg_we),
   .reg_wdata   (reg_wdata),
   .area1_dram  (area1_dram),
   .reg_rdata   (reg_rdata),
   .rd_done     (rd_done),
   .wait_active (wait_active)
);

// File: tb/tb_rws_ctrl.sv
`timescale 1ns/1ps
module tb_rws_ctrl;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        rd_req;
   logic [2:0]  area;
   logic [2:0]  space;
   logic [1:0]  long_sel;
   logic        wait_in;
   logic        area1_dram;
   logic        reg_we;
   logic [15:0] reg_wdata;
   logic [15:0] reg_rdata;
   logic        rd_done;
   logic        wait_active;

   always #2.5 clk = ~clk;

   rws_ctrl dut (.*);

   typedef struct { int len; string tag; } item_t;
   item_t exp_q[$];

   int   n_chk = 0;
   int   n_fail = 0;
   bit   finished = 0;
   logic [7:0] sh_rw = 8'hFF;

   task automatic chk(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // expected read length taken from the requirements
   function automatic int exp_len(int ar, int sp, int ls, int h, logic [7:0] bits);
      int  base;
      bit  smp;
      bit  b = bits[ar];
      case (sp)
         0: begin
            if (ar == 0 || ar == 2 || ar == 6) base = 2 + ls;
            else base = b ? 3 : 1;
            smp = b;
         end
         1: begin base = b ? 3 : 1; smp = b; end
         2: begin base = 5; smp = 1; end
         3: begin base = 3; smp = 0; end
         default: begin base = 1; smp = 0; end
      endcase
      if (smp && base > 1 && h + 1 > base) return h + 1;
      return base;
   endfunction

   // monitor: counts the clocks of each read and compares with the queue
   bit active = 0;
   int len = 0;
   bit wa_bad = 0;
   always @(posedge clk) begin
      if (!active && rd_req && rst_n === 1'b1) begin
         active = 1; len = 0; wa_bad = 0;
      end
   end
   always @(negedge clk) begin
      if (active) begin
         len++;
         if (wait_active !== (len > 1)) wa_bad = 1;
         if (rd_done === 1'b1) begin
            item_t it;
            if (exp_q.size() == 0) begin
               chk(0, "R10 done with no read", 1, 0);
            end else begin
               it = exp_q.pop_front();
               chk(len == it.len, it.tag, len, it.len);
               chk(!wa_bad, "R11 wait_active per clock", wa_bad, 0);
            end
            active = 0;
         end
      end
   end

   task automatic do_read(int ar, int sp, int ls, int h, string tag,
                          bit mid_wr, logic [15:0] wd, bit mid_req);
      item_t it;
      it.len = exp_len(ar, sp, ls, h, sh_rw);
      it.tag = tag;
      exp_q.push_back(it);
      @(negedge clk);
      area = 3'(ar); space = 3'(sp); long_sel = 2'(ls);
      rd_req = 1'b1; wait_in = (h > 0);
      @(posedge clk); #1 rd_req = 1'b0;
      if (mid_wr) begin reg_we = 1'b1; reg_wdata = wd; end
      fork
         begin if (h > 0) begin repeat (h) @(posedge clk); #1 wait_in = 1'b0; end end
         begin if (mid_wr) begin @(posedge clk); #1 reg_we = 1'b0; sh_rw = wd[15:8]; end end
         begin if (mid_req) begin @(posedge clk); #1 rd_req = 1'b1; @(posedge clk); #1 rd_req = 1'b0; end end
         begin @(negedge clk); while (rd_done !== 1'b1) @(negedge clk); end
      join
      @(negedge clk);
   endtask

   task automatic wr_reg(logic [15:0] d, bit a1d);
      @(negedge clk);
      reg_we = 1'b1; reg_wdata = d; area1_dram = a1d;
      @(posedge clk); #1 reg_we = 1'b0;
      sh_rw = d[15:8];
      @(negedge clk);
   endtask

   initial begin
      #(5.0 * 100000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; rd_req = 1'b0; area = '0; space = '0; long_sel = '0;
      wait_in = 1'b0; area1_dram = 1'b0; reg_we = 1'b0; reg_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(reg_rdata == 16'hFFFF, "R1 reset reg", int'(reg_rdata), 16'hFFFF);
      chk(rd_done == 1'b0, "R1 reset done", int'(rd_done), 0);
      chk(wait_active == 1'b0, "R1 reset wait_active", int'(wait_active), 0);

      do_read(3, 0, 0, 0, "R5 area3 bit1 no wait", 0, '0, 0);
      do_read(3, 0, 0, 5, "R5 area3 bit1 wait held 5", 0, '0, 0);
      do_read(1, 0, 0, 2, "R5 area1 bit1 wait 2", 0, '0, 0);
      do_read(3, 2, 0, 0, "R8 mux io no wait", 0, '0, 0);
      do_read(0, 0, 2, 0, "R6 area0 long 3", 0, '0, 0);
      do_read(0, 0, 2, 6, "R6 area0 long 3 wait 6", 0, '0, 0);
      do_read(5, 1, 0, 4, "R7 dram long pitch wait 4", 0, '0, 0);
      do_read(4, 3, 0, 5, "R9 peripheral fixed", 0, '0, 0);
      do_read(4, 4, 0, 5, "R9 onchip mem fixed", 0, '0, 0);
      do_read(7, 6, 0, 0, "R9 code 6 fixed", 0, '0, 0);
      do_read(3, 0, 0, 0, "R10 second request ignored", 0, '0, 1);
      for (int k = 0; k < 3; k++) begin
         chk(rd_done == 1'b0 && wait_active == 1'b0, "R10 idle after ignored request",
             int'({rd_done, wait_active}), 0);
         @(negedge clk);
      end

      wr_reg(16'h0000, 1'b0);
      chk(reg_rdata == 16'h00FF, "R2 clear ctrl, low byte ignored", int'(reg_rdata), 16'h00FF);
      wr_reg(16'h0000, 1'b1);
      chk(reg_rdata == 16'h00FD, "R3 ww cleared with area1 dram", int'(reg_rdata), 16'h00FD);
      wr_reg(16'hFFFF, 1'b0);
      chk(reg_rdata == 16'hFFFF, "R3 ww set", int'(reg_rdata), 16'hFFFF);
      wr_reg(16'hF300, 1'b0);
      chk(reg_rdata == 16'hF3FF, "R2 per-area bits, low writes ignored", int'(reg_rdata), 16'hF3FF);

      do_read(3, 0, 0, 5, "R4 area3 bit0 wait ignored", 0, '0, 0);
      do_read(2, 0, 0, 6, "R6 area2 bit0 wait ignored", 0, '0, 0);
      do_read(3, 1, 0, 4, "R7 dram short pitch", 0, '0, 0);
      do_read(3, 2, 0, 7, "R8 mux io bit0 wait 7", 0, '0, 0);
      do_read(1, 0, 0, 0, "R12 write during read", 1, 16'hF100, 0);
      chk(reg_rdata == 16'hF1FF, "R12 write landed", int'(reg_rdata), 16'hF1FF);
      do_read(1, 0, 0, 3, "R4 area1 bit0 after write", 0, '0, 0);

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R10 every read completed", exp_q.size(), 0);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule